// File: doc/BRIEF.md
# Clock and Calendar Update Engine

This block holds a time of day (seconds, minutes, hours) and a calendar (day of week, day of month, month, two-digit year). It advances them by one second per update. Updates are paced by a half-second tick from an oscillator divider that sits outside the block. Each update is announced in advance by an update-in-progress flag. The clock also keeps a second, host-visible copy of the time. After each update that copy is refreshed from the working copy, unless the host has asked for the copy to be frozen.

The bytes can be held in BCD or in plain binary. The hour can be 24-hour, or 12-hour with a PM marker in bit 7. An optional daylight-saving rule moves the hour forward in spring and back in autumn. After every update the new time is compared with three alarm bytes. A one-cycle pulse marks the end of each update, and a second one-cycle pulse marks an alarm match.

A simple write port and a combinational read port stand in for the host bus. Mode selections arrive as static inputs.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, every time and calendar byte reads 00, except day of week, day of month and month, which read 01. The alarm bytes read 00, and uip_o, upd_end_o and alarm_o are low.
- R2: While run_i is high, the first half-tick after run_i rises starts an update, and after that every second half-tick starts one. While run_i is low, half-ticks start nothing. On a starting half-tick, uip_o goes high in the next cycle and stays high for WARN_CYCLES cycles. The new time is then readable, uip_o is low, and upd_end_o is high for exactly one cycle.
- R3: While inhibit_i is 1, the host copy keeps its value across updates and uip_o stays 0. The working copy keeps counting. The first update after inhibit_i clears shows the working copy's advanced time.
- R4: With bin_i=0 (BCD), seconds and minutes count 00..59 as BCD, so 09 is followed by 10. In 24-hour mode (h24_i=1) hours count 00..23. 23:59:59 is followed by 00:00:00.
- R5: With bin_i=1, the same ranges count in plain binary: 09h is followed by 0Ah, and 3Bh:3Bh with hour 17h wraps to 00:00:00.
- R6: With h24_i=0, the hour is 1..12 and bit 7 set means PM. 11:59:59 AM is followed by 12 PM (92h in BCD), 12:59:59 PM by 1 PM (81h), and 11:59:59 PM by 12 AM (12h) together with a date advance.
- R7: At midnight the day of week goes 7 to 1. The day of month wraps after the month's last day: 30 days for months 4, 6, 9 and 11; in month 2, 29 days when the year is divisible by 4 and 28 otherwise; 31 days for the rest. Month 12 wraps to 1 and increments the year, and year 99 wraps to 00.
- R8: After each update, alarm_o pulses together with upd_end_o when the new seconds, minutes and hours each equal their alarm byte. An alarm byte whose bits 7:6 are both 1 matches any value.
- R9: With dst_en_i=1, on a Sunday (day of week 1) in month 4 with day of month 1..7, 01:59:59 is followed by 03:00:00. On any other day the hour advances normally.
- R10: With dst_en_i=1, on a Sunday in month 10 with day of month 25..31, the first time 01:59:59 passes, the hour returns to 01:00:00. The second pass the same day goes to 02:00:00.
- R11: The address map is: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 8 seconds alarm, 9 minutes alarm, 10 hours alarm. All other addresses read 00. A write to a time address updates both the host copy and the working copy in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_tick_i | input | 1 | One-cycle pulse every half second |
| run_i | input | 1 | Counting enabled; low stops updates and resets the tick phase |
| inhibit_i | input | 1 | Freeze the host copy, force uip_o low |
| bin_i | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| h24_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| dst_en_i | input | 1 | Enable daylight-saving jumps |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 8 | Read data from host copy or alarm bytes |
| uip_o | output | 1 | Update in progress warning |
| upd_end_o | output | 1 | One-cycle pulse at the end of each update |
| alarm_o | output | 1 | One-cycle pulse when the updated time matches the alarm |

## Verification
The increment logic is tested by loading the time just before each carry boundary: a plain digit step, a seconds-to-minutes carry, midnight, month end, year end, February in leap and non-leap years, and a 30-day month. Each load tells apart one carry path and one month-length rule. The same boundaries are then run again in binary and in 12-hour mode, which separates the decimal digit adjust from the binary wrap and the AM/PM turnover from the date advance. For daylight saving, matching and non-matching Sundays are compared, and the autumn fallback is run twice so the one-shot behaviour is seen. For the alarm, don't-care bytes are compared with fully specified bytes and with a single mismatching byte.

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int WARN_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_tick_i,
  input  logic       run_i,
  input  logic       inhibit_i,
  input  logic       bin_i,
  input  logic       h24_i,
  input  logic       dst_en_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [3:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       uip_o,
  output logic       upd_end_o,
  output logic       alarm_o
);
  localparam int NT = 7;
  localparam int NA = 3;
  localparam int ABASE = 8;
  localparam int CW = $clog2(WARN_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WARN_CYCLES - 1);

  logic [NT-1:0][7:0] loc, usr, nxt;
  logic [NA-1:0][7:0] alm;
  logic [CW-1:0] cnt;
  logic busy, phase, fell_q, fell_d, match;

  function automatic logic [6:0] dec(input logic [7:0] b, input logic bin);
    if (bin) return b[6:0];
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    if (bin) return {1'b0, v};
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  logic [6:0] s, m, h, h12i, dw, dm, mo, yr, dim;
  logic [6:0] s_n, m_n, h_n, dw_n, dm_n, mo_n, yr_n, h12o;
  logic [7:0] h12e;
  logic sc, hc, dc, moc, set_fb;

  always_comb begin
    s    = dec(loc[0], bin_i);
    m    = dec(loc[1], bin_i);
    h12i = dec({1'b0, loc[2][6:0]}, bin_i);
    if (h24_i) h = dec(loc[2], bin_i);
    else       h = ((h12i == 7'd12) ? 7'd0 : h12i) + (loc[2][7] ? 7'd12 : 7'd0);
    dw = dec(loc[3], bin_i);
    dm = dec(loc[4], bin_i);
    mo = dec(loc[5], bin_i);
    yr = dec(loc[6], bin_i);

    sc  = (s == 7'd59);
    hc  = sc && (m == 7'd59);
    dc  = hc && (h == 7'd23);
    s_n = sc ? 7'd0 : s + 7'd1;
    m_n = sc ? ((m == 7'd59) ? 7'd0 : m + 7'd1) : m;
    h_n = hc ? ((h == 7'd23) ? 7'd0 : h + 7'd1) : h;

    set_fb = 1'b0;
    if (dst_en_i && hc && (h == 7'd1) && (dw == 7'd1)) begin
      if ((mo == 7'd4) && (dm <= 7'd7)) h_n = 7'd3;
      else if ((mo == 7'd10) && (dm >= 7'd25) && !fell_q) begin
        h_n    = 7'd1;
        set_fb = 1'b1;
      end
    end

    case (mo)
      7'd2:                     dim = (yr[1:0] == 2'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  dim = 7'd30;
      default:                  dim = 7'd31;
    endcase

    moc  = dc && (dm >= dim);
    dw_n = dc ? ((dw >= 7'd7) ? 7'd1 : dw + 7'd1) : dw;
    dm_n = dc ? ((dm >= dim) ? 7'd1 : dm + 7'd1) : dm;
    mo_n = moc ? ((mo >= 7'd12) ? 7'd1 : mo + 7'd1) : mo;
    yr_n = (moc && (mo >= 7'd12)) ? ((yr >= 7'd99) ? 7'd0 : yr + 7'd1) : yr;

    h12o = ((h_n % 7'd12) == 7'd0) ? 7'd12 : (h_n % 7'd12);
    h12e = enc(h12o, bin_i);

    nxt[0] = enc(s_n, bin_i);
    nxt[1] = enc(m_n, bin_i);
    nxt[2] = h24_i ? enc(h_n, bin_i) : {(h_n >= 7'd12), h12e[6:0]};
    nxt[3] = enc(dw_n, bin_i);
    nxt[4] = enc(dm_n, bin_i);
    nxt[5] = enc(mo_n, bin_i);
    nxt[6] = enc(yr_n, bin_i);

    fell_d = dc ? 1'b0 : (set_fb ? 1'b1 : fell_q);
  end

  always_comb begin
    match = 1'b1;
    for (int i = 0; i < NA; i++)
      if (!((alm[i][7:6] == 2'b11) || (alm[i] == nxt[i]))) match = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin
        loc[i] <= ((i >= 3) && (i <= 5)) ? 8'h01 : 8'h00;
        usr[i] <= ((i >= 3) && (i <= 5)) ? 8'h01 : 8'h00;
      end
      alm       <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      phase     <= 1'b0;
      fell_q    <= 1'b0;
      upd_end_o <= 1'b0;
      alarm_o   <= 1'b0;
    end else begin
      upd_end_o <= 1'b0;
      alarm_o   <= 1'b0;
      if (!run_i) begin
        phase <= 1'b0;
        busy  <= 1'b0;
      end else if (busy && (cnt == LAST)) begin
        busy      <= 1'b0;
        loc       <= nxt;
        fell_q    <= fell_d;
        upd_end_o <= 1'b1;
        alarm_o   <= match;
        if (!inhibit_i) usr <= nxt;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
      if (run_i && half_tick_i) begin
        phase <= ~phase;
        if (!phase) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end
      if (wr_en_i) begin
        for (int i = 0; i < NT; i++)
          if (wr_addr_i == 4'(i)) begin
            loc[i] <= wr_data_i;
            usr[i] <= wr_data_i;
          end
        for (int i = 0; i < NA; i++)
          if (wr_addr_i == 4'(ABASE + i)) alm[i] <= wr_data_i;
      end
    end
  end

  assign uip_o = busy & ~inhibit_i;

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NT; i++)
      if (rd_addr_i == 4'(i)) rd_data_o = usr[i];
    for (int i = 0; i < NA; i++)
      if (rd_addr_i == 4'(ABASE + i)) rd_data_o = alm[i];
  end
endmodule

module rtc_calendar_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       inhibit_i,
  input logic       wr_en_i,
  input logic [3:0] rd_addr_i,
  input logic [7:0] rd_data_o,
  input logic       uip_o,
  input logic       upd_end_o,
  input logic       alarm_o
);
  assert_uip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |-> !uip_o);
  assert_frozen_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_i && !wr_en_i) ##1 $stable(rd_addr_i) |-> $stable(rd_data_o));
  assert_end_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end_o |=> !upd_end_o);
  assert_uip_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end_o |-> !uip_o);
  assert_alarm_on_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> upd_end_o);
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inhibit_i(inhibit_i), .wr_en_i(wr_en_i),
  .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .uip_o(uip_o),
  .upd_end_o(upd_end_o), .alarm_o(alarm_o)
);

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic half = 0, run = 0, inh = 0, bin = 0, h24 = 1, dst = 0, we = 0;
  logic [3:0] wa = 0, ra = 0;
  logic [7:0] wd = 0, rd;
  logic uip, upd_end, alarm;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic se, sa, su;

  always #2 clk = ~clk;

  rtc_calendar_core #(.WARN_CYCLES(W)) u_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .half_tick_i(half), .run_i(run), .inhibit_i(inh),
    .bin_i(bin), .h24_i(h24), .dst_en_i(dst), .wr_en_i(we), .wr_addr_i(wa),
    .wr_data_i(wd), .rd_addr_i(ra), .rd_data_o(rd), .uip_o(uip),
    .upd_end_o(upd_end), .alarm_o(alarm));

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); we = 1; wa = a; wd = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rchk(string tag, logic [3:0] a, logic [7:0] e);
    @(negedge clk); ra = a; #1; chk(tag, rd, e);
  endtask

  task automatic set_time(logic [7:0] h, logic [7:0] m, logic [7:0] s);
    wr(2, h); wr(1, m); wr(0, s);
  endtask

  task automatic set_date(logic [7:0] dw, logic [7:0] dm, logic [7:0] mo, logic [7:0] yr);
    wr(3, dw); wr(4, dm); wr(5, mo); wr(6, yr);
  endtask

  task automatic one_second();
    se = 0; sa = 0; su = 0;
    @(negedge clk); half = 1;
    @(negedge clk); half = 0;
    repeat (W + 3) begin
      if (uip) su = 1;
      if (upd_end) se = 1;
      if (alarm) sa = 1;
      @(negedge clk);
    end
    half = 1;
    @(negedge clk); half = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rchk("R1 sec", 0, 8'h00); rchk("R1 min", 1, 8'h00); rchk("R1 hour", 2, 8'h00);
    rchk("R1 dow", 3, 8'h01); rchk("R1 dom", 4, 8'h01); rchk("R1 mon", 5, 8'h01);
    rchk("R1 year", 6, 8'h00); rchk("R1 alarm", 10, 8'h00);
    chk("R1 outputs", {5'd0, uip, upd_end, alarm}, 8'h00);
  endtask

  task automatic t_timing();
    run = 1;
    @(negedge clk); half = 1;
    @(negedge clk); half = 0;
    chk("R2 uip first", {7'd0, uip}, 8'h01);
    repeat (W - 1) @(negedge clk);
    chk("R2 uip last", {6'd0, uip, upd_end}, 8'h02);
    @(negedge clk);
    chk("R2 end pulse", {6'd0, uip, upd_end}, 8'h01);
    ra = 0; #1; chk("R2 new second", rd, 8'h01);
    @(negedge clk);
    chk("R2 pulse one cycle", {7'd0, upd_end}, 8'h00);
    half = 1; @(negedge clk); half = 0;
    repeat (W + 3) @(negedge clk);
    rchk("R2 odd tick no update", 0, 8'h01);
    @(negedge clk); run = 0;
    @(negedge clk); half = 1; @(negedge clk); half = 0;
    repeat (W + 3) @(negedge clk);
    rchk("R2 stopped", 0, 8'h01);
    run = 1;
    one_second();
    chk("R2 restart first tick", {7'd0, se}, 8'h01);
    rchk("R2 restart value", 0, 8'h02);
  endtask

  task automatic t_bcd();
    bin = 0; h24 = 1;
    set_time(8'h10, 8'h20, 8'h09); one_second();
    rchk("R4 digit carry", 0, 8'h10);
    set_time(8'h23, 8'h59, 8'h59); set_date(8'h07, 8'h31, 8'h12, 8'h99); one_second();
    rchk("R4 sec wrap", 0, 8'h00); rchk("R4 min wrap", 1, 8'h00); rchk("R4 hour wrap", 2, 8'h00);
    rchk("R7 dow wrap", 3, 8'h01); rchk("R7 dom wrap", 4, 8'h01);
    rchk("R7 month wrap", 5, 8'h01); rchk("R7 year wrap", 6, 8'h00);
  endtask

  task automatic t_bin();
    bin = 1;
    set_time(8'h05, 8'h06, 8'h09); one_second();
    rchk("R5 binary step", 0, 8'h0A);
    set_time(8'h17, 8'h3B, 8'h3B); set_date(8'h02, 8'h05, 8'h03, 8'h10); one_second();
    rchk("R5 binary sec", 0, 8'h00); rchk("R5 binary hour", 2, 8'h00);
    rchk("R5 binary dom", 4, 8'h06);
    bin = 0;
  endtask

  task automatic t_12h();
    h24 = 0; bin = 0;
    set_date(8'h03, 8'h10, 8'h05, 8'h20);
    set_time(8'h11, 8'h59, 8'h59); one_second();
    rchk("R6 noon", 2, 8'h92); rchk("R6 noon date", 4, 8'h10);
    set_time(8'h92, 8'h59, 8'h59); one_second();
    rchk("R6 one pm", 2, 8'h81);
    set_time(8'h91, 8'h59, 8'h59); one_second();
    rchk("R6 midnight", 2, 8'h12); rchk("R6 date advance", 4, 8'h11);
    h24 = 1;
  endtask

  task automatic t_cal();
    set_time(8'h23, 8'h59, 8'h59); set_date(8'h01, 8'h28, 8'h02, 8'h24); one_second();
    rchk("R7 leap feb", 4, 8'h29);
    set_time(8'h23, 8'h59, 8'h59); set_date(8'h01, 8'h28, 8'h02, 8'h23); one_second();
    rchk("R7 plain feb dom", 4, 8'h01); rchk("R7 plain feb mon", 5, 8'h03);
    set_time(8'h23, 8'h59, 8'h59); set_date(8'h01, 8'h30, 8'h04, 8'h23); one_second();
    rchk("R7 april end", 5, 8'h05);
    set_time(8'h23, 8'h59, 8'h59); set_date(8'h01, 8'h30, 8'h01, 8'h23); one_second();
    rchk("R7 jan 31", 4, 8'h31);
  endtask

  task automatic t_alarm();
    wr(8, 8'h05); wr(9, 8'hC0); wr(10, 8'hC0);
    set_time(8'h07, 8'h33, 8'h04); one_second();
    chk("R8 dont care match", {6'd0, se, sa}, 8'h03);
    one_second();
    chk("R8 no match", {6'd0, se, sa}, 8'h02);
    wr(8, 8'h10); wr(9, 8'h20); wr(10, 8'h05);
    set_time(8'h05, 8'h20, 8'h09); one_second();
    chk("R8 full match", {7'd0, sa}, 8'h01);
    wr(10, 8'h06);
    set_time(8'h05, 8'h20, 8'h09); one_second();
    chk("R8 hour mismatch", {7'd0, sa}, 8'h00);
    rchk("R11 alarm read", 10, 8'h06);
  endtask

  task automatic t_dst();
    dst = 1;
    set_date(8'h01, 8'h05, 8'h04, 8'h21); set_time(8'h01, 8'h59, 8'h59); one_second();
    rchk("R9 spring jump", 2, 8'h03);
    set_date(8'h02, 8'h06, 8'h04, 8'h21); set_time(8'h01, 8'h59, 8'h59); one_second();
    rchk("R9 weekday normal", 2, 8'h02);
    set_date(8'h01, 8'h27, 8'h10, 8'h21); set_time(8'h01, 8'h59, 8'h59); one_second();
    rchk("R10 fall back", 2, 8'h01); rchk("R10 fall back min", 1, 8'h00);
    wr(1, 8'h59); wr(0, 8'h59); one_second();
    rchk("R10 second pass", 2, 8'h02);
    dst = 0;
  endtask

  task automatic t_inhibit();
    set_time(8'h04, 8'h00, 8'h10);
    @(negedge clk); inh = 1;
    one_second(); chk("R3 uip low", {7'd0, su}, 8'h00);
    one_second(); one_second();
    rchk("R3 frozen", 0, 8'h10);
    wr(1, 8'h30);
    rchk("R11 write while frozen", 1, 8'h30);
    @(negedge clk); inh = 0;
    one_second();
    rchk("R3 local kept counting", 0, 8'h14);
    rchk("R11 local took write", 1, 8'h30);
    rchk("R11 unused address", 7, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_timing(); t_bcd(); t_bin(); t_12h();
    t_cal(); t_alarm(); t_dst(); t_inhibit();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule